// File: doc/BRIEF.md
# Triggered Transient Trace Recorder

This block keeps a short, frozen history of an 8-bit encoded sensor word around an external event, so that a fast transient can be rebuilt offline. One sample is taken per clock; at the intended 5 ns clock a full trace of 30 samples spans 150 ns. The trigger input is shared with the stimulus source, so every run starts at the same moment relative to the disturbance.

To cover a span longer than one trace, the same stimulus is repeated and the capture start is pushed back by a whole number of 30-sample windows, from 0 to 4 windows (750 ns in total). Once the chain is full it stops shifting, raises `done`, and serves any stage through a combinational indexed read until software-side logic pulses `rearm`.

The controller has four states. ST_IDLE waits for a trigger edge. On that edge, with a zero offset it goes straight to ST_CAPTURE, otherwise to ST_DELAY. ST_DELAY counts offset x 30 cycles and then moves to ST_CAPTURE. ST_CAPTURE shifts for exactly 30 cycles and then moves to ST_FULL. ST_FULL holds until `rearm`, which returns it to ST_IDLE.

Top module: `transient_trace_rec`

## Requirements
- R1: After reset `done` is low, the controller is idle, and every stage read through `rd_idx` 0..29 returns 0.
- R2: A run starts only on a low-to-high transition of `trig_in` seen through a two-flop synchronizer. A level that is still high when the block returns to idle does not start a new run.
- R3: If `trig_in` rises before clock edge E0, the oldest recorded word is the `sample_in` value present at edge E3 + 30*offset.
- R4: A capture takes exactly 30 consecutive samples. `done` is low after edge E31 + 30*offset and high after edge E32 + 30*offset.
- R5: The offset on `win_ofs` is taken at the edge that accepts the trigger and is held for the run. Offsets 1 to 4 delay capture by 30*offset cycles, and any value above 4 behaves as 4.
- R6: `rd_word` is a combinational function of `rd_idx`. Index 0 is the oldest sample, index 29 the newest, and indices 30 and 31 return 0.
- R7: While `done` is high the stored words do not change. `rearm` acts only in that state: it clears `done` and leaves the stored words readable until the next capture begins. A `rearm` during delay or capture has no effect.
- R8: Trigger edges that arrive while a run is delayed, capturing or full are ignored and do not alter the recorded trace.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low reset |
| trig_in | input | 1 | Asynchronous trigger shared with the stimulus source |
| win_ofs | input | 3 | Start offset in whole 30-sample windows (0..4, larger values clamp) |
| rearm | input | 1 | Returns a full recorder to idle |
| sample_in | input | 8 | Encoded sensor word |
| rd_idx | input | 5 | Stage to read, 0 = oldest |
| rd_word | output | 8 | Word stored at `rd_idx` |
| done | output | 1 | Trace is complete and frozen |

## Verification
The bench feeds a sample that equals a running cycle count, so each stored word shows exactly which edge captured it. An off-by-one in the synchronizer or the delay counter therefore shifts every word. It runs offsets 0 to 4 plus an out-of-range 7. A missing clamp would wait too long, and a design that reads the offset after acceptance would pick up the value changed mid-run. It pulses the trigger and `rearm` during a run: a design that honoured either would restart or drop the trace and return wrong words or wrong `done` timing. It also re-arms with the trigger still high, which a level-sensitive start would wrongly turn into a second capture. Finally it reads indices 30 and 31, and reads the chain after re-arm, to catch a design that aliases out-of-range indices or clears the trace on re-arm.

// File: rtl/trace_rec_pkg.sv
package trace_rec_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_DELAY   = 2'd1,
        ST_CAPTURE = 2'd2,
        ST_FULL    = 2'd3
    } rec_state_t;
endpackage

// File: rtl/trig_edge_sync.sv
module trig_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_async,
    output logic rise
);
    logic meta_q, sync_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= trig_async;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign rise = sync_q & ~prev_q;

    // R2: a detected edge lasts a single cycle
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/trace_ctrl.sv
module trace_ctrl
    import trace_rec_pkg::*;
#(
    parameter int DEPTH   = 30,
    parameter int MAX_OFS = 4,
    localparam int OFS_W  = $clog2(MAX_OFS + 1),
    localparam int CNT_W  = $clog2(MAX_OFS * DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise,
    input  logic             rearm,
    input  logic [OFS_W-1:0] ofs,
    output logic             shift_en,
    output logic             done
);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
    localparam logic [OFS_W-1:0] MAXO_C  = OFS_W'(MAX_OFS);

    rec_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] lim_q, lim_d;
    logic [OFS_W-1:0] ofs_c;
    logic [CNT_W-1:0] lim_new;

    always_comb begin
        ofs_c   = (ofs > MAXO_C) ? MAXO_C : ofs;
        lim_new = CNT_W'(ofs_c) * DEPTH_C;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            lim_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            lim_q   <= lim_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        lim_d   = lim_q;
        unique case (state_q)
            ST_IDLE: begin
                if (rise) begin
                    lim_d   = lim_new;
                    cnt_d   = '0;
                    state_d = (lim_new == '0) ? ST_CAPTURE : ST_DELAY;
                end
            end
            ST_DELAY: begin
                if (cnt_q == lim_q - CNT_W'(1)) begin
                    cnt_d   = '0;
                    state_d = ST_CAPTURE;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            ST_CAPTURE: begin
                if (cnt_q == DEPTH_C - CNT_W'(1)) begin
                    cnt_d   = '0;
                    state_d = ST_FULL;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            ST_FULL: begin
                if (rearm) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        shift_en = 1'b0;
        done     = 1'b0;
        unique case (state_q)
            ST_CAPTURE: shift_en = 1'b1;
            ST_FULL:    done     = 1'b1;
            default: ;
        endcase
    end

    // R4: last capture cycle always leads to the full state
    a_r4_capture_len: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CAPTURE && cnt_q == DEPTH_C - CNT_W'(1)) |=> state_q == ST_FULL);
    // R5: the delay counter never passes its latched limit
    a_r5_delay_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DELAY) |-> (cnt_q < lim_q));
    // R8: once a run is under way only rearm from full brings back idle
    a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && !(state_q == ST_FULL && rearm)) |=> state_q != ST_IDLE);
    // R2: an accepted edge always leaves idle
    a_r2_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && rise) |=> state_q != ST_IDLE);
endmodule

// File: rtl/trace_chain.sv
module trace_chain #(
    parameter int WORD_W = 8,
    parameter int DEPTH  = 30,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic [WORD_W-1:0] din,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_word
);
    logic [DEPTH-1:0][WORD_W-1:0] stage_q;

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[g] <= '0;
            end else if (shift_en) begin
                if (g == DEPTH - 1) stage_q[g] <= din;
                else                stage_q[g] <= stage_q[(g + 1) % DEPTH];
            end
        end
    end

    always_comb begin
        if (rd_idx < IDX_W'(DEPTH)) rd_word = stage_q[rd_idx];
        else                        rd_word = '0;
    end

    // R7: no shift means the whole chain holds
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(stage_q));
    // R6: the newest stage takes the input word on a shift
    a_r6_newest: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> stage_q[DEPTH-1] == $past(din));
endmodule

// File: rtl/transient_trace_rec.sv
module transient_trace_rec #(
    parameter int WORD_W  = 8,
    parameter int DEPTH   = 30,
    parameter int MAX_OFS = 4,
    localparam int OFS_W  = $clog2(MAX_OFS + 1),
    localparam int IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_in,
    input  logic [OFS_W-1:0]  win_ofs,
    input  logic              rearm,
    input  logic [WORD_W-1:0] sample_in,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_word,
    output logic              done
);
    logic rise;
    logic shift_en;

    trig_edge_sync u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig_async (trig_in),
        .rise       (rise)
    );

    trace_ctrl #(.DEPTH(DEPTH), .MAX_OFS(MAX_OFS)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise     (rise),
        .rearm    (rearm),
        .ofs      (win_ofs),
        .shift_en (shift_en),
        .done     (done)
    );

    trace_chain #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .din      (sample_in),
        .rd_idx   (rd_idx),
        .rd_word  (rd_word)
    );

    // R7: done and shifting never overlap
    a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && shift_en));
endmodule

// File: tb/transient_trace_rec_test.sv
module transient_trace_rec_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       trig_in = 1'b0;
    logic [2:0] win_ofs = '0;
    logic       rearm = 1'b0;
    logic [7:0] sample_in;
    logic [4:0] rd_idx = '0;
    logic [7:0] rd_word;
    logic       done;

    int total = 0;
    int bad = 0;
    int tick = 0;
    bit finished = 0;

    always #4 clk = ~clk;
    always @(negedge clk) tick <= tick + 1;
    assign sample_in = tick[7:0];

    transient_trace_rec uut (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .win_ofs(win_ofs),
        .rearm(rearm), .sample_in(sample_in), .rd_idx(rd_idx),
        .rd_word(rd_word), .done(done)
    );

    // offsets applied in the table walk (7 must clamp to 4)
    localparam int NV = 6;
    localparam int OFS_TAB [NV] = '{0, 1, 2, 3, 4, 7};

    task automatic chk(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    // returns first sample tick of the run
    task automatic do_run(int ofs, bit disturb, output int base);
        int eff = (ofs > 4) ? 4 : ofs;
        int lat = 32 + eff * 30;
        int n0;
        step();
        win_ofs = 3'(ofs);
        trig_in = 1'b1;
        n0 = tick;
        for (int c = 1; c <= lat; c++) begin
            step();
            if (c == 3) win_ofs = 3'd0;      // R5: change after acceptance
            if (disturb) begin
                if (c == 10) trig_in = 1'b0;  // R8: second edge mid-run
                if (c == 15) trig_in = 1'b1;
                if (c == 20) rearm = 1'b1;    // R7: rearm outside full
                if (c == 21) rearm = 1'b0;
            end
            if (c == lat) chk(done == 1'b0, "R4 done early", done, 0);
        end
        step();
        chk(done == 1'b1, "R4 done late", done, 1);
        base = n0 + 3 + eff * 30;
        for (int i = 0; i < 30; i++) begin
            rd_idx = 5'(i);
            #1;
            chk(rd_word == 8'(base + i), "R3 R5 R6 word", rd_word, (base + i) & 255);
        end
    endtask

    task automatic do_rearm();
        step();
        rearm = 1'b1;
        step();
        rearm = 1'b0;
        chk(done == 1'b0, "R7 rearm clears done", done, 0);
        repeat (3) step();
    endtask

    initial begin
        int base;
        bit all_zero;
        repeat (3) step();
        // R1: reset state
        chk(done == 1'b0, "R1 done at reset", done, 0);
        all_zero = 1;
        for (int i = 0; i < 30; i++) begin
            rd_idx = 5'(i);
            #1;
            if (rd_word != 8'd0) all_zero = 0;
        end
        chk(all_zero, "R1 chain zero", all_zero, 1);
        rst_n = 1'b1;
        repeat (2) step();
        chk(done == 1'b0, "R1 idle after reset", done, 0);

        // table walk over offsets
        for (int v = 0; v < NV; v++) begin
            do_run(OFS_TAB[v], 1'b0, base);
            // R7: frozen while full, extra cycles with changing input
            repeat (5) step();
            rd_idx = 5'd29;
            #1;
            chk(rd_word == 8'(base + 29), "R7 frozen", rd_word, (base + 29) & 255);
            trig_in = 1'b0;
            do_rearm();
        end

        // R8 and R7: trigger edge and rearm during a run are ignored
        do_run(1, 1'b1, base);
        trig_in = 1'b0;

        // R6: out-of-range indices
        rd_idx = 5'd30;
        #1;
        chk(rd_word == 8'd0, "R6 index 30", rd_word, 0);
        rd_idx = 5'd31;
        #1;
        chk(rd_word == 8'd0, "R6 index 31", rd_word, 0);
        do_rearm();

        // R7: trace readable after rearm
        rd_idx = 5'd0;
        #1;
        chk(rd_word == 8'(base), "R7 kept after rearm", rd_word, base & 255);

        // R2: trigger held high across rearm starts nothing
        do_run(0, 1'b0, base);
        do_rearm();
        repeat (40) step();
        chk(done == 1'b0, "R2 held level no restart", done, 0);
        rd_idx = 5'd0;
        #1;
        chk(rd_word == 8'(base), "R2 chain untouched", rd_word, base & 255);
        trig_in = 1'b0;
        repeat (3) step();

        // R2: a fresh edge does start again
        do_run(0, 1'b0, base);
        trig_in = 1'b0;

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule